// File: doc/BRIEF.md
# Streaming Sobel Gradient Engine

The block sits on a camera's pixel stream and turns 8-bit grayscale samples, arriving one per clock in raster order, into a horizontal and a vertical image derivative for every interior neighbourhood. Two line stores keep the two previous image rows. Together with the live pixel they form a 3×3 window that slides one column per accepted pixel. Two fixed Sobel kernels are applied to that window. Each kernel evaluates all nine weighted taps at once and reduces them through a registered adder tree. Multiply, partial-sum and final-sum stages therefore work on three different pixels in the same cycle.

Each result carries the column and row of the window centre, so a downstream stage can store it or feed a corner detector without counting pixels itself. A start-of-frame and a start-of-line marker travel with the pixels to keep the position in step with the sensor. Without markers the position wraps at the end of a line and at the end of a frame. At the default 320×240 size, one pixel per cycle gives about 76,800 cycles per frame, so 30 frames per second needs well under 75 MHz.

Top module: `sobel_gradient_stream`

## Requirements
- R1: While reset is high and afterwards, until a pixel has gone through the pipeline, `out_valid` is 0 and both gradients are 0.
- R2: For an interior centre (x,y), `out_gx` = (p[y-1][x+1] + 2·p[y][x+1] + p[y+1][x+1]) − (p[y-1][x-1] + 2·p[y][x-1] + p[y+1][x-1]), as a two's-complement value.
- R3: For an interior centre (x,y), `out_gy` = (p[y+1][x-1] + 2·p[y+1][x] + p[y+1][x+1]) − (p[y-1][x-1] + 2·p[y-1][x] + p[y-1][x+1]), as a two's-complement value.
- R4: An accepted pixel at column c and row r, with c ≥ 1 and r ≥ 1, yields exactly one result tagged `out_col` = c−1 and `out_row` = r−1. Pixels in column 0 or row 0 yield no result.
- R5: A result whose centre lies in column 0 or row 0 has both gradients equal to 0.
- R6: The result for a pixel accepted at rising edge E appears, with `out_valid` high, after rising edge E+3. It is held for one cycle.
- R7: A cycle with `in_valid` low is ignored: its pixel and both markers have no effect on any later result, and it produces no result.
- R8: A pixel with `in_sof` high is at column 0, row 0. A pixel with `in_sol` high (and `in_sof` low) is at column 0 of the next row. Without markers, the column advances by one and wraps to 0 after IMG_W−1; the row then advances and wraps to 0 after IMG_H−1. After reset, the first pixel is at (0,0).
- R9: Gradients span −1020 to +1020 without overflow in the 11-bit signed outputs. A full-scale step edge gives exactly ±1020.
- R10: Whenever `out_valid` is 0, both gradient outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel present this cycle |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_sol | input | 1 | Pixel is the first of a line |
| in_pix | input | 8 | Grayscale sample |
| out_valid | output | 1 | Result present this cycle |
| out_col | output | $clog2(IMG_W) | Centre column of the result |
| out_row | output | $clog2(IMG_H) | Centre row of the result |
| out_gx | output | 11 | Signed horizontal derivative |
| out_gy | output | 11 | Signed vertical derivative |

## Verification
Every result is due exactly three rising edges after the edge that accepts its newest pixel. The bench drives each pixel on a falling edge. It records the cycle counter at that moment and files the expected result, due four counter ticks later, in an ordered list. At each falling edge, the bench compares the outputs against the head of that list when its due cycle has come, and otherwise requires `out_valid` low with zero gradients. Because of this, a result that is early, late, duplicated or spurious fails in the cycle where it appears, even when idle cycles are inserted between pixels.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W       = 8;
    localparam int COEF_W      = 3;
    localparam int PROD_W      = PIX_W + COEF_W;
    localparam int SUM_W       = PROD_W + 2;
    localparam int GRAD_W      = 11;
    localparam int TAPS        = 3;
    localparam int PIPE_STAGES = 4;

    typedef logic        [PIX_W-1:0]  pix_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [GRAD_W-1:0] grad_t;

    // win[row][col]: row 0 is the oldest line, col 0 the oldest column
    typedef logic [TAPS-1:0][TAPS-1:0][PIX_W-1:0] win_t;
    typedef logic [TAPS-1:0][PIX_W-1:0]           column_t;

    typedef enum logic {
        DIR_HORIZ = 1'b0,
        DIR_VERT  = 1'b1
    } dir_e;

    // Sobel weight: sign along the derivative axis, 2 on the middle line across it
    function automatic coef_t tap_coef(dir_e dir, int r, int c);
        int along;
        int across;
        if (dir == DIR_HORIZ) begin
            along  = c - 1;
            across = r;
        end else begin
            along  = r - 1;
            across = c;
        end
        return coef_t'(along * ((across == 1) ? 2 : 1));
    endfunction

    function automatic prod_t tap_mul(pix_t p, coef_t k);
        prod_t pe;
        prod_t ke;
        pe = prod_t'({1'b0, p});
        ke = prod_t'(k);
        return pe * ke;
    endfunction

endpackage

// File: rtl/sobel_pos_track.sv
module sobel_pos_track #(
    parameter int IMG_W = 320,
    parameter int IMG_H = 240,
    parameter int COL_W = 9,
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_sol,
    output logic [COL_W-1:0] cur_col,
    output logic [ROW_W-1:0] cur_row
);

    localparam logic [COL_W-1:0] LAST_COL = COL_W'(IMG_W - 1);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(IMG_H - 1);

    logic [COL_W-1:0] prev_col_q;
    logic [ROW_W-1:0] prev_row_q;
    logic [ROW_W-1:0] next_row;

    assign next_row = (prev_row_q == LAST_ROW) ? '0 : prev_row_q + ROW_W'(1);

    always_comb begin
        if (in_sof) begin
            cur_col = '0;
            cur_row = '0;
        end else if (in_sol || prev_col_q == LAST_COL) begin
            cur_col = '0;
            cur_row = next_row;
        end else begin
            cur_col = prev_col_q + COL_W'(1);
            cur_row = prev_row_q;
        end
    end

    // reset parks the position on the last pixel so the next one is (0,0)
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_col_q <= LAST_COL;
            prev_row_q <= LAST_ROW;
        end else if (in_valid) begin
            prev_col_q <= cur_col;
            prev_row_q <= cur_row;
        end
    end

endmodule

// File: rtl/sobel_line_window.sv
module sobel_line_window
    import sobel_pkg::*;
#(
    parameter int IMG_W = 320,
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  pix_t             in_pix,
    input  logic [COL_W-1:0] in_col,
    output win_t             win
);

    localparam int LINES = TAPS - 1;

    // chain[0] is the live pixel, chain[k+1] the same column k+1 lines earlier
    logic [LINES:0][PIX_W-1:0] chain;
    column_t                   fresh;
    win_t                      win_q;

    assign chain[0]        = in_pix;
    assign fresh[TAPS-1]   = chain[0];

    for (genvar k = 0; k < LINES; k++) begin : g_line
        pix_t mem [IMG_W];

        assign chain[k+1]        = mem[in_col];
        assign fresh[TAPS-2-k]   = chain[k+1];

        always_ff @(posedge clk) begin
            if (in_valid) begin
                mem[in_col] <= chain[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
        end else if (in_valid) begin
            for (int r = 0; r < TAPS; r++) begin
                for (int c = 0; c < TAPS - 1; c++) begin
                    win_q[r][c] <= win_q[r][c+1];
                end
                win_q[r][TAPS-1] <= fresh[r];
            end
        end
    end

    assign win = win_q;

endmodule

// File: rtl/sobel_kernel.sv
module sobel_kernel
    import sobel_pkg::*;
#(
    parameter dir_e DIR = DIR_HORIZ
) (
    input  logic clk,
    input  logic rst,
    input  win_t win,
    output sum_t result
);

    logic [TAPS-1:0][TAPS-1:0][PROD_W-1:0] prod_w;
    logic [TAPS-1:0][TAPS-1:0][PROD_W-1:0] prod_q;
    sum_t                                  part_d [TAPS];
    sum_t                                  part_q [TAPS];
    sum_t                                  total_d;
    sum_t                                  total_q;

    // nine weighted taps evaluated side by side
    for (genvar r = 0; r < TAPS; r++) begin : g_row
        for (genvar c = 0; c < TAPS; c++) begin : g_col
            localparam coef_t K = tap_coef(DIR, r, c);
            assign prod_w[r][c] = tap_mul(win[r][c], K);
        end
    end

    // first tree level: one sum per window line
    always_comb begin
        for (int r = 0; r < TAPS; r++) begin
            part_d[r] = '0;
            for (int c = 0; c < TAPS; c++) begin
                part_d[r] = part_d[r] + sum_t'($signed(prod_q[r][c]));
            end
        end
    end

    // second tree level
    always_comb begin
        total_d = '0;
        for (int r = 0; r < TAPS; r++) begin
            total_d = total_d + part_q[r];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            total_q <= '0;
            for (int r = 0; r < TAPS; r++) begin
                part_q[r] <= '0;
            end
        end else begin
            prod_q  <= prod_w;
            total_q <= total_d;
            for (int r = 0; r < TAPS; r++) begin
                part_q[r] <= part_d[r];
            end
        end
    end

    assign result = total_q;

endmodule

// File: rtl/sobel_gradient_stream.sv
module sobel_gradient_stream
    import sobel_pkg::*;
#(
    parameter  int IMG_W = 320,
    parameter  int IMG_H = 240,
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [COL_W-1:0]  out_col,
    output logic [ROW_W-1:0]  out_row,
    output logic [GRAD_W-1:0] out_gx,
    output logic [GRAD_W-1:0] out_gy
);

    typedef struct packed {
        logic             valid;
        logic             border;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] row;
    } tag_t;

    logic [COL_W-1:0] cur_col;
    logic [ROW_W-1:0] cur_row;
    win_t             win;
    sum_t             gx_sum;
    sum_t             gy_sum;
    tag_t             tag_d;
    tag_t             tag_q [PIPE_STAGES];
    tag_t             tag_out;
    logic             emit_grad;

    sobel_pos_track #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H),
        .COL_W (COL_W),
        .ROW_W (ROW_W)
    ) u_pos (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_sol   (in_sol),
        .cur_col  (cur_col),
        .cur_row  (cur_row)
    );

    sobel_line_window #(
        .IMG_W (IMG_W),
        .COL_W (COL_W)
    ) u_window (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_pix   (in_pix),
        .in_col   (cur_col),
        .win      (win)
    );

    sobel_kernel #(.DIR(DIR_HORIZ)) u_kern_x (
        .clk    (clk),
        .rst    (rst),
        .win    (win),
        .result (gx_sum)
    );

    sobel_kernel #(.DIR(DIR_VERT)) u_kern_y (
        .clk    (clk),
        .rst    (rst),
        .win    (win),
        .result (gy_sum)
    );

    // the newest pixel completes the window centred one column and one row back
    always_comb begin
        tag_d.valid  = in_valid && (cur_col != '0) && (cur_row != '0);
        tag_d.border = (cur_col == COL_W'(1)) || (cur_row == ROW_W'(1));
        tag_d.col    = cur_col - COL_W'(1);
        tag_d.row    = cur_row - ROW_W'(1);
    end

    // tag travels alongside window, product, line-sum and total registers
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < PIPE_STAGES; s++) begin
                tag_q[s] <= '0;
            end
        end else begin
            tag_q[0] <= tag_d;
            for (int s = 1; s < PIPE_STAGES; s++) begin
                tag_q[s] <= tag_q[s-1];
            end
        end
    end

    assign tag_out   = tag_q[PIPE_STAGES-1];
    assign emit_grad = tag_out.valid && !tag_out.border;

    assign out_valid = tag_out.valid;
    assign out_col   = tag_out.col;
    assign out_row   = tag_out.row;
    assign out_gx    = emit_grad ? grad_t'(gx_sum) : '0;
    assign out_gy    = emit_grad ? grad_t'(gy_sum) : '0;

endmodule

// File: rtl/sobel_gradient_stream_chk.sv
module sobel_gradient_stream_chk
    import sobel_pkg::*;
#(
    parameter  int IMG_W = 320,
    parameter  int IMG_H = 240,
    localparam int COL_W = $clog2(IMG_W),
    localparam int ROW_W = $clog2(IMG_H)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic [COL_W-1:0]         out_col,
    input logic [ROW_W-1:0]         out_row,
    input logic signed [GRAD_W-1:0] out_gx,
    input logic signed [GRAD_W-1:0] out_gy
);

    localparam logic signed [GRAD_W-1:0] GRAD_MAX = GRAD_W'(1020);
    localparam logic signed [GRAD_W-1:0] GRAD_MIN = -GRAD_W'(1020);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 4)) else $error("result without pixel four edges back"); // R6

    AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_col == '0 || out_row == '0)) |-> (out_gx == '0 && out_gy == '0))
        else $error("border centre with nonzero gradient"); // R5

    AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_gx == '0 && out_gy == '0)) else $error("gradient without valid"); // R10

    AST_GRAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_gx >= GRAD_MIN && out_gx <= GRAD_MAX && out_gy >= GRAD_MIN && out_gy <= GRAD_MAX))
        else $error("gradient outside range"); // R9

    AST_TAG_BOUNDS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_col < COL_W'(IMG_W - 1) && out_row < ROW_W'(IMG_H - 1)))
        else $error("centre tag outside interior span"); // R4

endmodule

bind sobel_gradient_stream sobel_gradient_stream_chk #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_col   (out_col),
    .out_row   (out_row),
    .out_gx    (out_gx),
    .out_gy    (out_gy)
);

// File: tb/test_sobel_gradient_stream.sv
`timescale 1ns/1ps
module test_sobel_gradient_stream;
    import sobel_pkg::*;

    localparam int W  = 6;
    localparam int H  = 5;
    localparam int CW = $clog2(W);
    localparam int RW = $clog2(H);

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic              in_sof;
    logic              in_sol;
    logic [PIX_W-1:0]  in_pix;
    logic              out_valid;
    logic [CW-1:0]     out_col;
    logic [RW-1:0]     out_row;
    logic [GRAD_W-1:0] out_gx;
    logic [GRAD_W-1:0] out_gy;

    always #2.5 clk = ~clk;

    sobel_gradient_stream #(.IMG_W(W), .IMG_H(H)) i_sobel_gradient_stream (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol),
        .in_pix(in_pix), .out_valid(out_valid), .out_col(out_col), .out_row(out_row),
        .out_gx(out_gx), .out_gy(out_gy)
    );

    typedef struct {
        int    col;
        int    row;
        int    gx;
        int    gy;
        int    due;
        string rq_pos;
        string rq_gx;
        string rq_gy;
    } exp_t;

    exp_t pend[$];
    int   img [H][W];
    int   cyc      = 0;
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   mon_on   = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", rq, what, act, expv, cyc);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int ref_gx(input int x, input int y);
        return (img[y-1][x+1] + 2 * img[y][x+1] + img[y+1][x+1])
             - (img[y-1][x-1] + 2 * img[y][x-1] + img[y+1][x-1]);
    endfunction

    function automatic int ref_gy(input int x, input int y);
        return (img[y+1][x-1] + 2 * img[y+1][x] + img[y+1][x+1])
             - (img[y-1][x-1] + 2 * img[y-1][x] + img[y-1][x+1]);
    endfunction

    function automatic int pattern(input int kind, input int f, input int c, input int r);
        case (kind)
            0: return 3 * c + 5 * r + f;
            1: return (c >= 3) ? 255 : 0;
            2: return (r >= 2) ? 255 : 0;
            3: return (c < 3) ? 255 : 0;
            default: return (c * 53 + r * 97 + f * 29 + c * r * 11) % 256;
        endcase
    endfunction

    // R7: idle cycles carry garbage pixel and markers that must be ignored
    task automatic idle(input int n);
        in_valid = 1'b0;
        in_sof   = 1'b1;
        in_sol   = 1'b1;
        in_pix   = 8'hA5;
        repeat (n) @(negedge clk);
        in_sof   = 1'b0;
        in_sol   = 1'b0;
    endtask

    task automatic send(input int c, input int r, input int val, input bit sof, input bit sol, input string prq);
        exp_t e;
        img[r][c] = val;
        in_valid  = 1'b1;
        in_sof    = sof;
        in_sol    = sol;
        in_pix    = PIX_W'(val);
        if (c >= 1 && r >= 1) begin
            e.col    = c - 1;
            e.row    = r - 1;
            e.due    = cyc + 4;
            e.rq_pos = prq;
            if (e.col == 0 || e.row == 0) begin
                e.gx = 0; e.gy = 0; e.rq_gx = "R5"; e.rq_gy = "R5";
            end else begin
                e.gx    = ref_gx(e.col, e.row);
                e.gy    = ref_gy(e.col, e.row);
                e.rq_gx = (iabs(e.gx) == 1020) ? "R9" : "R2";
                e.rq_gy = (iabs(e.gy) == 1020) ? "R9" : "R3";
            end
            pend.push_back(e);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_sol   = 1'b0;
    endtask

    task automatic run_frame(input int f, input int kind, input int npix, input bit marks,
                             input bit stall, input string prq);
        for (int idx = 0; idx < npix; idx++) begin
            int c;
            int r;
            c = idx % W;
            r = idx / W;
            send(c, r, pattern(kind, f, c, r), marks && idx == 0, marks && c == 0 && idx != 0, prq);
            if (stall && (idx % 4) == 3) idle(1 + idx % 3);
        end
    endtask

    // result monitor: one comparison set per falling edge
    always @(negedge clk) begin
        exp_t e;
        if (mon_on) begin
            if (pend.size() > 0 && pend[0].due == cyc) begin
                e = pend.pop_front();
                check(out_valid == 1'b1, "R6", "out_valid at due cycle", int'(out_valid), 1);
                check(int'(out_col) == e.col, e.rq_pos, "centre column", int'(out_col), e.col);
                check(int'(out_row) == e.row, e.rq_pos, "centre row", int'(out_row), e.row);
                check(int'($signed(out_gx)) == e.gx, e.rq_gx, "gx", int'($signed(out_gx)), e.gx);
                check(int'($signed(out_gy)) == e.gy, e.rq_gy, "gy", int'($signed(out_gy)), e.gy);
            end else begin
                check(out_valid == 1'b0, "R7", "spurious out_valid", int'(out_valid), 0);
                check(out_gx == '0 && out_gy == '0, "R10", "gx while idle", int'($signed(out_gx)), 0);
            end
        end
    end

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_sol   = 1'b0;
        in_pix   = '0;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
            check(out_gx == '0 && out_gy == '0, "R1", "gx after reset", int'($signed(out_gx)), 0);
        end
        mon_on = 1'b1;

        run_frame(0, 0, W * H, 1'b1, 1'b0, "R4");
        run_frame(1, 1, W * H, 1'b1, 1'b1, "R4");
        run_frame(2, 2, W * H, 1'b1, 1'b0, "R4");
        run_frame(3, 3, W * H, 1'b1, 1'b1, "R4");
        run_frame(4, 4, W * H, 1'b1, 1'b1, "R7");
        // R8: abandoned frame, restart by start-of-frame, then a markerless frame
        run_frame(5, 4, 2 * W + 3, 1'b1, 1'b0, "R8");
        run_frame(6, 4, W * H, 1'b1, 1'b1, "R8");
        run_frame(7, 0, W * H, 1'b0, 1'b0, "R8");

        repeat (10) @(negedge clk);
        check(pend.size() == 0, "R6", "results still outstanding", pend.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R6 watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule